// File: doc/BRIEF.md
# Multilevel Cell Retention Drift Tester

This block is a test sequencer for a memory array whose cells each hold one of several analog levels. Each level is presented on the memory port as a thermometer-coded group of digits. After a start pulse, the sequencer writes the highest level (all digits set) to every cell of a ROWS x COLS array. It then idles for a retention interval taken from a 32-bit input. Finally it reads the array back one row at a time, comparing each returned code against the written one.

Each row is read as a page-mode burst. One activate cycle opens the row, and then every column of that row is read on consecutive cycles. The per-cell mismatch flags are collected into a row buffer. They are then streamed out as a drift bitmap, one beat per cell over a valid/ready handshake, with the row and column indices sent alongside each bit. External software can then look for failing bits, bitlines and wordlines. A done flag and a sticky any-fail flag report the result of the run.

Top module: `mlc_drift_tester`

## Requirements
- R1: During and after reset, before any start pulse, done_o, any_fail_o, bm_valid_o, mem_act_o, mem_we_o and mem_re_o are all low.
- R2: A start_i pulse begins a run only when the block is idle or done. A start_i pulse during a run is ignored: it causes no extra writes and no change to the sampled wait value.
- R3: The fill writes every cell exactly once, one per cycle, in row-major order (column fastest). The write data is the top level, all DIGITS bits set (11111 for five digits).
- R4: The wait value is sampled at start. The first activate occurs exactly wait_cycles_i + 1 cycles after the last fill write, so a value of 0 starts readback on the cycle right after the last write.
- R5: Each row is read as one mem_act_o cycle carrying the row index, followed immediately by COLS mem_re_o cycles on consecutive cycles. The burst holds the same row and uses columns 0 to COLS-1 in ascending order. Rows are visited in ascending order.
- R6: A cell's fail bit is 1 exactly when its returned read code differs from the all-ones top level.
- R7: The bitmap carries one beat per cell in row-major order, with bm_row_o and bm_col_o giving the cell. While bm_valid_o is high and bm_ready_i is low, the beat is held unchanged.
- R8: The next row is not activated until every bitmap beat of the previous row has been accepted. Memory reads never overlap bitmap output.
- R9: done_o rises after the last beat is accepted and stays high until the next start. any_fail_o is the OR of all fail bits of the current run; it is cleared by an accepted start and is sticky otherwise.
- R10: While done_o is high, no memory operation is issued and bm_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| wait_cycles_i | input | WAIT_W | Retention interval in cycles |
| done_o | output | 1 | Run complete, held until next start |
| any_fail_o | output | 1 | Sticky OR of all fail bits of the run |
| mem_act_o | output | 1 | Row activate (opens mem_row_o) |
| mem_we_o | output | 1 | Cell write strobe |
| mem_re_o | output | 1 | Cell read strobe |
| mem_row_o | output | ROW_W | Row address |
| mem_col_o | output | COL_W | Column address |
| mem_wdata_o | output | DIGITS | Write code |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DIGITS | Read code |
| bm_valid_o | output | 1 | Bitmap beat valid |
| bm_ready_i | input | 1 | Bitmap beat accepted |
| bm_fail_o | output | 1 | Fail flag of the cell |
| bm_row_o | output | ROW_W | Row of the cell |
| bm_col_o | output | COL_W | Column of the cell |

## Verification
The bench measures the gap between the last write and the first activate for waits of 0, 1, 3 and 7. An off-by-one timer would shift the activate by one cycle, and a design that skips the zero case would stall or wrap the 32-bit counter. Faults that drop only the top digit, the bottom digit, or every digit are injected at the first, middle and last cells. A compare that checks only part of the code, or a buffer that stores bits at the wrong index, would therefore misplace or lose flags. Bitmap backpressure patterns check that beats hold steady and that the next row's burst waits. A start pulse carrying a different wait value in the middle of a run checks that no run restarts and that the wait value is not re-sampled.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_WAIT,
    ST_ACT,
    ST_READ,
    ST_COLLECT,
    ST_EMIT,
    ST_DONE
  } mdt_state_e;
endpackage

// File: rtl/mdt_wait_timer.sv
module mdt_wait_timer #(
  parameter int WAIT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WAIT_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic              zero_o,
  output logic              last_o
);
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
  assign last_o = (cnt_q == WAIT_W'(1));
endmodule

// File: rtl/mdt_code_check.sv
module mdt_code_check #(
  parameter int DIGITS = 5
) (
  input  logic [DIGITS-1:0] code_i,
  output logic [DIGITS-1:0] top_code_o,
  output logic              mismatch_o
);
  logic [DIGITS-1:0] miss;

  // thermometer top level: every digit set
  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    assign top_code_o[i] = 1'b1;
    assign miss[i]       = code_i[i] ^ top_code_o[i];
  end

  assign mismatch_o = |miss;
endmodule

// File: rtl/mdt_row_buffer.sv
module mdt_row_buffer #(
  parameter int COLS  = 16,
  parameter int COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             cap_i,
  input  logic             fail_i,
  output logic             full_o,
  input  logic             pop_i,
  output logic [COL_W-1:0] col_o,
  output logic             bit_o,
  output logic             last_o
);
  logic [COLS-1:0]  bits_q;
  logic [COL_W:0]   rx_q;
  logic [COL_W-1:0] tx_q;

  assign full_o = (rx_q == (COL_W+1)'(COLS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else if (clr_i) begin
      bits_q <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
    end else begin
      if (cap_i && !full_o) begin
        bits_q[rx_q[COL_W-1:0]] <= fail_i;
        rx_q <= rx_q + 1'b1;
      end
      if (pop_i) tx_q <= tx_q + 1'b1;
    end
  end

  assign col_o  = tx_q;
  assign bit_o  = bits_q[tx_q];
  assign last_o = (tx_q == COL_W'(COLS-1));
endmodule

// File: rtl/mlc_drift_tester.sv
module mlc_drift_tester
  import mdt_pkg::*;
#(
  parameter int ROWS   = 16,
  parameter int COLS   = 16,
  parameter int DIGITS = 5,
  parameter int WAIT_W = 32,
  localparam int ROW_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_W = (COLS > 1) ? $clog2(COLS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_cycles_i,
  output logic              done_o,
  output logic              any_fail_o,
  output logic              mem_act_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ROW_W-1:0]  mem_row_o,
  output logic [COL_W-1:0]  mem_col_o,
  output logic [DIGITS-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DIGITS-1:0] mem_rdata_i,
  output logic              bm_valid_o,
  input  logic              bm_ready_i,
  output logic              bm_fail_o,
  output logic [ROW_W-1:0]  bm_row_o,
  output logic [COL_W-1:0]  bm_col_o
);
  mdt_state_e       state_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             fail_q;

  logic start_acc, row_last, col_last;
  logic tmr_zero, tmr_last;
  logic mismatch, cap, buf_full, buf_last, pop;
  logic [DIGITS-1:0] top_code;

  assign start_acc = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign row_last  = (row_q == ROW_W'(ROWS-1));
  assign col_last  = (col_q == COL_W'(COLS-1));
  assign cap       = mem_rvalid_i && (state_q == ST_READ || state_q == ST_COLLECT);
  assign pop       = bm_valid_o && bm_ready_i;

  mdt_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_acc),
    .load_val_i (wait_cycles_i),
    .dec_i      (state_q == ST_WAIT),
    .zero_o     (tmr_zero),
    .last_o     (tmr_last)
  );

  mdt_code_check #(.DIGITS(DIGITS)) u_check (
    .code_i     (mem_rdata_i),
    .top_code_o (top_code),
    .mismatch_o (mismatch)
  );

  mdt_row_buffer #(.COLS(COLS), .COL_W(COL_W)) u_rowbuf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == ST_ACT),
    .cap_i  (cap),
    .fail_i (mismatch),
    .full_o (buf_full),
    .pop_i  (pop),
    .col_o  (bm_col_o),
    .bit_o  (bm_fail_o),
    .last_o (buf_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_i) begin
            state_q <= ST_FILL;
            row_q   <= '0;
            col_q   <= '0;
          end
        end
        ST_FILL: begin
          if (col_last) begin
            col_q <= '0;
            if (row_last) begin
              row_q   <= '0;
              state_q <= tmr_zero ? ST_ACT : ST_WAIT;
            end else begin
              row_q <= row_q + 1'b1;
            end
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_WAIT: if (tmr_last) state_q <= ST_ACT;
        ST_ACT: begin
          col_q   <= '0;
          state_q <= ST_READ;
        end
        ST_READ: begin
          if (col_last) begin
            col_q   <= '0;
            state_q <= ST_COLLECT;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        ST_COLLECT: if (buf_full) state_q <= ST_EMIT;
        ST_EMIT: begin
          // next row opens only after the whole row bitmap is taken
          if (bm_ready_i && buf_last) begin
            if (row_last) begin
              state_q <= ST_DONE;
            end else begin
              row_q   <= row_q + 1'b1;
              state_q <= ST_ACT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              fail_q <= 1'b0;
    else if (start_acc)       fail_q <= 1'b0;
    else if (cap && mismatch) fail_q <= 1'b1;
  end

  assign done_o      = (state_q == ST_DONE);
  assign any_fail_o  = fail_q;
  assign mem_act_o   = (state_q == ST_ACT);
  assign mem_we_o    = (state_q == ST_FILL);
  assign mem_re_o    = (state_q == ST_READ);
  assign mem_row_o   = row_q;
  assign mem_col_o   = col_q;
  assign mem_wdata_o = top_code;
  assign bm_valid_o  = (state_q == ST_EMIT);
  assign bm_row_o    = row_q;
endmodule

// File: rtl/mdt_checker.sv
module mdt_checker #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DIGITS = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              done_o,
  input logic              any_fail_o,
  input logic              mem_act_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic [ROW_W-1:0]  mem_row_o,
  input logic [COL_W-1:0]  mem_col_o,
  input logic [DIGITS-1:0] mem_wdata_o,
  input logic              bm_valid_o,
  input logic              bm_ready_i,
  input logic              bm_fail_o,
  input logic [ROW_W-1:0]  bm_row_o,
  input logic [COL_W-1:0]  bm_col_o
);
  a_r3_write_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_wdata_o == {DIGITS{1'b1}}));

  a_r5_single_op: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_act_o, mem_we_o, mem_re_o}));

  a_r5_burst_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_act_o |=> (mem_re_o && mem_col_o == '0 && $stable(mem_row_o)));

  a_r7_beat_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_valid_o && !bm_ready_i) |=>
      (bm_valid_o && $stable(bm_row_o) && $stable(bm_col_o) && $stable(bm_fail_o)));

  a_r8_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bm_valid_o |-> !(mem_act_o || mem_re_o || mem_we_o));

  a_r9_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  a_r9_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_fail_o && !start_i) |=> any_fail_o);

  a_r10_quiet_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(mem_act_o || mem_we_o || mem_re_o || bm_valid_o));
endmodule

bind mlc_drift_tester mdt_checker #(
  .ROW_W  (ROW_W),
  .COL_W  (COL_W),
  .DIGITS (DIGITS)
) u_mdt_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .done_o      (done_o),
  .any_fail_o  (any_fail_o),
  .mem_act_o   (mem_act_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_row_o   (mem_row_o),
  .mem_col_o   (mem_col_o),
  .mem_wdata_o (mem_wdata_o),
  .bm_valid_o  (bm_valid_o),
  .bm_ready_i  (bm_ready_i),
  .bm_fail_o   (bm_fail_o),
  .bm_row_o    (bm_row_o),
  .bm_col_o    (bm_col_o)
);

// File: tb/mlc_drift_tester_test.sv
module mlc_drift_tester_test;
  localparam int R = 3, C = 4, D = 5, N = R * C;
  localparam int RW = 2, CW = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic          start_i = 1'b0;
  logic [31:0]   wait_cycles_i = '0;
  logic          done_o, any_fail_o, mem_act_o, mem_we_o, mem_re_o;
  logic [RW-1:0] mem_row_o, bm_row_o;
  logic [CW-1:0] mem_col_o, bm_col_o;
  logic [D-1:0]  mem_wdata_o;
  logic          mem_rvalid_i = 1'b0;
  logic [D-1:0]  mem_rdata_i = '0;
  logic          bm_valid_o, bm_fail_o;
  logic          bm_ready_i = 1'b1;

  mlc_drift_tester #(.ROWS(R), .COLS(C), .DIGITS(D), .WAIT_W(32)) uut (
    .clk_i, .rst_ni, .start_i, .wait_cycles_i, .done_o, .any_fail_o,
    .mem_act_o, .mem_we_o, .mem_re_o, .mem_row_o, .mem_col_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i, .bm_valid_o, .bm_ready_i, .bm_fail_o,
    .bm_row_o, .bm_col_o
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [D-1:0] fmask [N];
  logic [D-1:0] cells [N];
  int cur_wait = 0, ready_mode = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk_i) cyc <= cyc + 1;

  // memory model: two-cycle read latency, fault mask applied on read
  logic         p1_v = 1'b0;
  logic [D-1:0] p1_d = '0;
  always @(posedge clk_i) begin
    p1_v <= 1'b0;
    if (mem_we_o && int'(mem_row_o) * C + int'(mem_col_o) < N)
      cells[int'(mem_row_o) * C + int'(mem_col_o)] <= mem_wdata_o;
    if (mem_re_o && int'(mem_row_o) * C + int'(mem_col_o) < N) begin
      p1_v <= 1'b1;
      p1_d <= cells[int'(mem_row_o) * C + int'(mem_col_o)] ^ fmask[int'(mem_row_o) * C + int'(mem_col_o)];
    end
    mem_rvalid_i <= p1_v;
    mem_rdata_i  <= p1_d;
  end

  // bitmap backpressure patterns
  initial begin
    forever begin
      @(posedge clk_i); #1;
      case (ready_mode)
        0: bm_ready_i = 1'b1;
        1: bm_ready_i = cyc[0];
        default: bm_ready_i = (cyc % 4 == 3);
      endcase
    end
  end

  // port monitor
  bit in_run = 0, hold_pend = 0;
  int wr_cnt = 0, rd_cnt = 0, act_cnt = 0, em_cnt = 0;
  int last_wr = 0, last_rd = 0;
  logic [RW-1:0] h_row; logic [CW-1:0] h_col; logic h_fail;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (start_i && !in_run) begin
        in_run = 1; wr_cnt = 0; rd_cnt = 0; act_cnt = 0; em_cnt = 0; hold_pend = 0;
      end else if (done_o) in_run = 0;

      if (hold_pend)
        chk(bm_valid_o && bm_row_o == h_row && bm_col_o == h_col && bm_fail_o == h_fail,
            "R7 hold", int'(bm_valid_o), 1);
      hold_pend = bm_valid_o && !bm_ready_i;
      h_row = bm_row_o; h_col = bm_col_o; h_fail = bm_fail_o;

      if (bm_valid_o && bm_ready_i) begin
        chk(int'(bm_row_o) * C + int'(bm_col_o) == em_cnt, "R7 order",
            int'(bm_row_o) * C + int'(bm_col_o), em_cnt);
        if (em_cnt < N)
          chk(bm_fail_o == (fmask[em_cnt] != '0), "R6 fail bit",
              int'(bm_fail_o), int'(fmask[em_cnt] != '0));
        em_cnt++;
      end
      if (mem_we_o) begin
        chk(mem_wdata_o == 5'b11111, "R3 top code", int'(mem_wdata_o), 31);
        chk(int'(mem_row_o) * C + int'(mem_col_o) == wr_cnt, "R3 fill order",
            int'(mem_row_o) * C + int'(mem_col_o), wr_cnt);
        chk(wr_cnt == 0 || cyc == last_wr + 1, "R3 one per cycle", cyc, last_wr + 1);
        wr_cnt++; last_wr = cyc;
      end
      if (mem_act_o) begin
        chk(int'(mem_row_o) == act_cnt, "R5 row order", int'(mem_row_o), act_cnt);
        chk(em_cnt == act_cnt * C, "R8 row drained", em_cnt, act_cnt * C);
        if (act_cnt == 0)
          chk(cyc - last_wr == cur_wait + 1, "R4 wait gap", cyc - last_wr, cur_wait + 1);
        act_cnt++; last_rd = cyc;
      end
      if (mem_re_o) begin
        chk(int'(mem_row_o) * C + int'(mem_col_o) == rd_cnt, "R5 burst address",
            int'(mem_row_o) * C + int'(mem_col_o), rd_cnt);
        chk(cyc == last_rd + 1, "R5 consecutive", cyc, last_rd + 1);
        last_rd = cyc; rd_cnt++;
      end
      if (done_o)
        chk(!(mem_act_o || mem_we_o || mem_re_o || bm_valid_o), "R10 quiet", 1, 0);
    end
  end

  task automatic run(input int w, input int rmode, input bit restart, input bit exp_fail);
    bit seen;
    cur_wait = w; ready_mode = rmode;
    @(posedge clk_i); #1; start_i = 1'b1; wait_cycles_i = 32'(w);
    @(posedge clk_i); #1; start_i = 1'b0;
    if (restart) begin
      repeat (3) @(posedge clk_i);
      #1; start_i = 1'b1; wait_cycles_i = 32'd50;
      @(posedge clk_i); #1; start_i = 1'b0;
    end
    seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk_i);
      seen = done_o;
    end
    chk(seen, "R9 done reached", int'(seen), 1);
    chk(wr_cnt == N, restart ? "R2 no restart writes" : "R3 write count", wr_cnt, N);
    chk(rd_cnt == N, "R5 read count", rd_cnt, N);
    chk(em_cnt == N, "R7 beat count", em_cnt, N);
    chk(any_fail_o == exp_fail, "R9 any fail", int'(any_fail_o), int'(exp_fail));
    repeat (5) @(negedge clk_i);
    chk(done_o == 1'b1, "R9 done held", int'(done_o), 1);
    chk(any_fail_o == exp_fail, "R9 fail held", int'(any_fail_o), int'(exp_fail));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!done_o && !any_fail_o && !bm_valid_o && !mem_act_o && !mem_we_o && !mem_re_o,
        "R1 reset state", int'(done_o | any_fail_o | bm_valid_o), 0);
    for (int i = 0; i < N; i++) fmask[i] = '0;
    @(posedge clk_i); #1; rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!done_o && !any_fail_o && !bm_valid_o && !mem_we_o, "R1 idle after reset",
        int'(done_o | any_fail_o | bm_valid_o | mem_we_o), 0);

    run(0, 0, 0, 0);
    fmask[0] = 5'b10000; fmask[6] = 5'b11111; fmask[11] = 5'b00001;
    run(7, 1, 0, 1);
    for (int i = 0; i < N; i++) fmask[i] = '0;
    fmask[4] = 5'b11000;
    run(3, 2, 1, 1);
    fmask[4] = '0;
    run(1, 0, 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule